// File: doc/BRIEF.md
# Memory Operand Effective Address Generator

This block decodes the addressing byte of a two-operand instruction (the 2-bit mode field, the 3-bit register/memory field and the operand-width bit) against the current values of the four address registers (BX, BP, SI, DI) and a 16-bit displacement. For a memory operand it returns the 16-bit effective address and the 2-bit code of the segment that the access uses by default. For a register operand (mode 11) it returns a flag and a 4-bit register index instead.

The decode unit presents one request per cycle with `in_valid_i` high. The result appears in the output registers on the next clock edge, marked by `out_valid_o`, and it stays there until the next accepted request. Segment override prefixes and the forming of the physical address are left to later stages.

Top module: `ea_gen`

## Requirements
- R1: The base/index sum is chosen by `rm_i`: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX.
- R2: With `mod_i`=00 (and `rm_i` other than 110), no displacement is added. The whole of `disp_i` is ignored.
- R3: With `mod_i`=01, only `disp_i[7:0]` is used. It is sign-extended to 16 bits before the add, and `disp_i[15:8]` is ignored.
- R4: With `mod_i`=10, the full 16-bit `disp_i` is added.
- R5: With `mod_i`=00 and `rm_i`=110, `ea_o` equals `disp_i`, no register is added, and the segment is DS.
- R6: `seg_o` uses the codes ES=00, CS=01, SS=10 and DS=11. A memory operand gives SS when `rm_i` is 010 or 011, or when `rm_i` is 110 with `mod_i` of 01 or 10. Every other memory operand gives DS.
- R7: With `mod_i`=11, `reg_op_o` is 1 and `reg_idx_o`={`wide_i`,`rm_i`}. Indices 0 to 7 are AL,CL,DL,BL,AH,CH,DH,BH and 8 to 15 are AX,CX,DX,BX,SP,BP,SI,DI. `ea_o` and `seg_o` are 0.
- R8: `out_valid_o` is high in exactly the cycles that follow a cycle with `in_valid_i` high. While `in_valid_i` is low, all result outputs hold their values.
- R9: All address arithmetic wraps modulo 2^16.
- R10: After reset, `out_valid_o`, `ea_o`, `seg_o`, `reg_op_o` and `reg_idx_o` are all 0.
- R11: For a memory operand, `reg_op_o` is 0 and `reg_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Request present this cycle |
| mod_i | input | 2 | Mode field of the addressing byte |
| rm_i | input | 3 | Register/memory field of the addressing byte |
| wide_i | input | 1 | Operand width: 1 selects a word register, 0 a byte register |
| disp_i | input | 16 | Displacement; only the low byte is used in mode 01 |
| bx_i | input | 16 | Current BX |
| bp_i | input | 16 | Current BP |
| si_i | input | 16 | Current SI |
| di_i | input | 16 | Current DI |
| out_valid_o | output | 1 | Registered result valid |
| ea_o | output | 16 | Effective address |
| seg_o | output | 2 | Default segment code |
| reg_op_o | output | 1 | Operand is a register |
| reg_idx_o | output | 4 | Register index {width, rm} |

## Verification
A wrong base or index choice, or a wrong displacement choice, shows up as a wrong `ea_o` in the first cycle after the offending request. The table of vectors places each mode/rm combination against register values that differ from one another, so any wrong selection produces a different address. A broken segment rule or register decode shows up in `seg_o` or `reg_idx_o` in the same cycle. Because the hold behaviour keeps the last result while no request is present, a stale or wrongly enabled output register is seen in the idle cycles that follow.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } seg_e;

  typedef enum logic [1:0] {
    MD_NODISP = 2'b00,
    MD_DISP8  = 2'b01,
    MD_DISP16 = 2'b10,
    MD_REG    = 2'b11
  } mod_e;

  localparam logic [2:0] RM_DIRECT = 3'b110;
endpackage

// File: rtl/ea_base_sel.sv
module ea_base_sel #(
  parameter int AW = 16
) (
  input  logic [2:0]    rm_i,
  input  logic          direct_i,
  input  logic [AW-1:0] bx_i,
  input  logic [AW-1:0] bp_i,
  input  logic [AW-1:0] si_i,
  input  logic [AW-1:0] di_i,
  output logic [AW-1:0] sum_o
);
  logic [AW-1:0] base_q, idx_q;

  always_comb begin
    base_q = '0;
    idx_q  = '0;
    if (!rm_i[2]) begin
      // paired modes: base in bit1, index in bit0
      base_q = rm_i[1] ? bp_i : bx_i;
      idx_q  = rm_i[0] ? di_i : si_i;
    end else begin
      unique case (rm_i[1:0])
        2'b00: idx_q  = si_i;
        2'b01: idx_q  = di_i;
        2'b10: base_q = direct_i ? '0 : bp_i;
        default: base_q = bx_i;
      endcase
    end
  end

  // modulo 2^AW
  assign sum_o = base_q + idx_q;
endmodule

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
  parameter int AW = 16,
  parameter int SW = 8
) (
  input  logic [1:0]    mod_i,
  input  logic          direct_i,
  input  logic [AW-1:0] disp_i,
  output logic [AW-1:0] disp_o
);
  import ea_pkg::*;
  localparam int XW = AW - SW;

  logic [AW-1:0] short_ext;

  generate
    if (XW > 0) begin : g_ext
      assign short_ext = {{XW{disp_i[SW-1]}}, disp_i[SW-1:0]};
    end else begin : g_noext
      assign short_ext = disp_i;
    end
  endgenerate

  always_comb begin
    unique case (mod_e'(mod_i))
      MD_NODISP: disp_o = direct_i ? disp_i : '0;
      MD_DISP8:  disp_o = short_ext;
      MD_DISP16: disp_o = disp_i;
      default:   disp_o = '0;
    endcase
  end
endmodule

// File: rtl/ea_seg_sel.sv
module ea_seg_sel (
  input  logic [1:0]   mod_i,
  input  logic [2:0]   rm_i,
  output ea_pkg::seg_e seg_o
);
  import ea_pkg::*;

  logic bp_based;

  always_comb begin
    bp_based = 1'b0;
    if (rm_i[2:1] == 2'b01) bp_based = 1'b1;
    if (rm_i == RM_DIRECT && mod_i != MD_NODISP) bp_based = 1'b1;
    seg_o = bp_based ? SEG_SS : SEG_DS;
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 16,
  parameter int SW = 8,
  parameter int RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [1:0]    mod_i,
  input  logic [RW-1:0] rm_i,
  input  logic          wide_i,
  input  logic [AW-1:0] disp_i,
  input  logic [AW-1:0] bx_i,
  input  logic [AW-1:0] bp_i,
  input  logic [AW-1:0] si_i,
  input  logic [AW-1:0] di_i,
  output logic          out_valid_o,
  output logic [AW-1:0] ea_o,
  output logic [1:0]    seg_o,
  output logic          reg_op_o,
  output logic [RW:0]   reg_idx_o
);
  import ea_pkg::*;

  logic          direct, is_reg;
  logic [AW-1:0] sum_c, disp_c, ea_c;
  seg_e          seg_c;

  assign is_reg = (mod_i == MD_REG);
  assign direct = (mod_i == MD_NODISP) && (rm_i == RM_DIRECT);

  ea_base_sel #(.AW(AW)) u_base (
    .rm_i     (rm_i),
    .direct_i (direct),
    .bx_i     (bx_i),
    .bp_i     (bp_i),
    .si_i     (si_i),
    .di_i     (di_i),
    .sum_o    (sum_c)
  );

  ea_disp_ext #(.AW(AW), .SW(SW)) u_disp (
    .mod_i    (mod_i),
    .direct_i (direct),
    .disp_i   (disp_i),
    .disp_o   (disp_c)
  );

  ea_seg_sel u_seg (
    .mod_i (mod_i),
    .rm_i  (rm_i),
    .seg_o (seg_c)
  );

  assign ea_c = sum_c + disp_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      ea_o        <= '0;
      seg_o       <= 2'b00;
      reg_op_o    <= 1'b0;
      reg_idx_o   <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        reg_op_o <= is_reg;
        if (is_reg) begin
          ea_o      <= '0;
          seg_o     <= 2'b00;
          reg_idx_o <= {wide_i, rm_i};
        end else begin
          ea_o      <= ea_c;
          seg_o     <= seg_c;
          reg_idx_o <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16,
  parameter int RW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic [1:0]    mod_i,
  input logic [RW-1:0] rm_i,
  input logic          wide_i,
  input logic [AW-1:0] disp_i,
  input logic          out_valid_o,
  input logic [AW-1:0] ea_o,
  input logic [1:0]    seg_o,
  input logic          reg_op_o,
  input logic [RW:0]   reg_idx_o
);
  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r8_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(ea_o) && $stable(seg_o) && $stable(reg_op_o) && $stable(reg_idx_o)));

  a_r7_reg_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mod_i == 2'b11) |=> (reg_op_o && reg_idx_o == {$past(wide_i), $past(rm_i)}));

  a_r7_reg_clears_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && reg_op_o) |-> (ea_o == '0 && seg_o == 2'b00));

  a_r5_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mod_i == 2'b00 && rm_i == 3'b110) |=> (ea_o == $past(disp_i) && seg_o == 2'b11));

  a_r6_seg_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !reg_op_o) |-> seg_o[1]);

  a_r11_mem_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !reg_op_o) |-> (reg_idx_o == '0));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .mod_i       (mod_i),
  .rm_i        (rm_i),
  .wide_i      (wide_i),
  .disp_i      (disp_i),
  .out_valid_o (out_valid_o),
  .ea_o        (ea_o),
  .seg_o       (seg_o),
  .reg_op_o    (reg_op_o),
  .reg_idx_o   (reg_idx_o)
);

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [1:0]  md;
    logic [2:0]  rm;
    logic        w;
    logic [15:0] disp;
    logic [15:0] exp_ea;
    logic [1:0]  exp_seg;
    logic        exp_reg;
    logic [3:0]  exp_idx;
  } vec_t;

  // BX=0892 BP=1000 SI=0200 DI=59A3 for all table rows
  localparam vec_t VEC [NVEC] = '{
    '{2'b10, 3'b001, 1'b1, 16'h2345, 16'h857A, 2'b11, 1'b0, 4'h0}, // R4 R1 BX+DI+d16
    '{2'b00, 3'b000, 1'b0, 16'hFFFF, 16'h0A92, 2'b11, 1'b0, 4'h0}, // R2 disp ignored
    '{2'b00, 3'b011, 1'b1, 16'h1111, 16'h69A3, 2'b10, 1'b0, 4'h0}, // R6 BP+DI SS
    '{2'b01, 3'b100, 1'b1, 16'h00F0, 16'h01F0, 2'b11, 1'b0, 4'h0}, // R3 negative d8
    '{2'b01, 3'b110, 1'b0, 16'hAB05, 16'h1005, 2'b10, 1'b0, 4'h0}, // R3 R6 high byte ignored
    '{2'b00, 3'b110, 1'b1, 16'h1234, 16'h1234, 2'b11, 1'b0, 4'h0}, // R5 direct
    '{2'b10, 3'b010, 1'b1, 16'h8000, 16'h9200, 2'b10, 1'b0, 4'h0}, // R4 R6 BP+SI
    '{2'b00, 3'b111, 1'b0, 16'h0000, 16'h0892, 2'b11, 1'b0, 4'h0}, // R1 BX
    '{2'b01, 3'b101, 1'b1, 16'h007F, 16'h5A22, 2'b11, 1'b0, 4'h0}, // R3 positive d8
    '{2'b11, 3'b100, 1'b1, 16'h5555, 16'h0000, 2'b00, 1'b1, 4'hC}, // R7 SP
    '{2'b11, 3'b100, 1'b0, 16'h5555, 16'h0000, 2'b00, 1'b1, 4'h4}, // R7 AH
    '{2'b10, 3'b110, 1'b1, 16'h0010, 16'h1010, 2'b10, 1'b0, 4'h0}  // R6 R11 BP+d16
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  md = 2'b00;
  logic [2:0]  rm = 3'b000;
  logic        w = 1'b0;
  logic [15:0] disp = '0;
  logic [15:0] bx = 16'h0892, bp = 16'h1000, si = 16'h0200, di = 16'h59A3;
  logic        out_valid;
  logic [15:0] ea;
  logic [1:0]  seg;
  logic        reg_op;
  logic [3:0]  reg_idx;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen u_ea_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .mod_i       (md),
    .rm_i        (rm),
    .wide_i      (w),
    .disp_i      (disp),
    .bx_i        (bx),
    .bp_i        (bp),
    .si_i        (si),
    .di_i        (di),
    .out_valid_o (out_valid),
    .ea_o        (ea),
    .seg_o       (seg),
    .reg_op_o    (reg_op),
    .reg_idx_o   (reg_idx)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (valid,ea,seg,reg,idx)", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pack_out();
    return {out_valid, ea, seg, reg_op, reg_idx};
  endfunction

  task automatic issue(input logic [1:0] m, input logic [2:0] r, input logic ww, input logic [15:0] d);
    md = m; rm = r; w = ww; disp = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL R8: watchdog expired, actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R10 reset", pack_out(), 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", pack_out(), 24'h0);

    // table walk, back-to-back requests
    for (int i = 0; i < NVEC; i++) begin
      md = VEC[i].md; rm = VEC[i].rm; w = VEC[i].w; disp = VEC[i].disp; in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R1 R2 R3 R4 R5 R6 R7 R11 vec %0d", i), pack_out(),
            {1'b1, VEC[i].exp_ea, VEC[i].exp_seg, VEC[i].exp_reg, VEC[i].exp_idx});
    end
    in_valid = 1'b0;

    // R8: idle cycle drops valid and holds the last result
    md = 2'b00; rm = 3'b000; disp = 16'h7777;
    @(negedge clk);
    check("R8 hold", pack_out(), {1'b0, 16'h1010, 2'b10, 1'b0, 4'h0});

    // R9: wrap on base+index and on disp
    bx = 16'hFFFF; si = 16'h0003;
    issue(2'b10, 3'b000, 1'b1, 16'h0010);
    check("R9 wrap sum", pack_out(), {1'b1, 16'h0012, 2'b11, 1'b0, 4'h0});
    bx = 16'h0005;
    issue(2'b01, 3'b111, 1'b0, 16'h3380);
    check("R9 R3 wrap negative", pack_out(), {1'b1, 16'hFF85, 2'b11, 1'b0, 4'h0});

    // R5: direct address ignores BP entirely
    bp = 16'hBEEF;
    issue(2'b00, 3'b110, 1'b0, 16'hFFFE);
    check("R5 direct with BP set", pack_out(), {1'b1, 16'hFFFE, 2'b11, 1'b0, 4'h0});

    // R7: register then memory, index cleared
    issue(2'b11, 3'b111, 1'b1, 16'h0000);
    check("R7 DI", pack_out(), {1'b1, 16'h0000, 2'b00, 1'b1, 4'hF});
    di = 16'h0001;
    issue(2'b00, 3'b101, 1'b1, 16'h0000);
    check("R11 after reg", pack_out(), {1'b1, 16'h0001, 2'b11, 1'b0, 4'h0});

    // R10: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 mid reset", pack_out(), 24'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule